// File: doc/BRIEF.md
# Parent-select clock divider

This block takes several parent clock sources and produces one divided output. It picks one parent and divides it by a programmable ratio. Every signal stays in a single system clock domain. Each parent arrives as a one-cycle enable strobe. The output is a strobe that fires once per N selected parent strobes.

A single control register holds two fields: a parent-select field and a ratio field. Each field has a position and a width set by parameters. A mode parameter chooses how the ratio field is decoded, either as n+1 or as 2^n. The register is written through a 32-bit port. The upper half of each write is a per-bit enable for the lower half, so software can update one field without touching the other. The register can be read back at any time.

Ratio changes wait for the running period to finish before they take effect. A change of the selected parent restarts the count from zero.

Top module: `clksel_divider`

## Requirements
- R1: On a write, control bit i (0..15) takes write-data bit i only when write-data bit 16+i is 1. All other control bits keep their value. A write whose upper half is zero changes nothing.
- R2: The read port always returns the 16 stored control bits in bits 15:0, with bits 31:16 reading as zero.
- R3: In linear mode, a ratio field value n produces one output strobe per n+1 selected parent strobes. A value of 0 passes every parent strobe through.
- R4: In power-of-two mode, a ratio field value n produces one output strobe per 2^n selected parent strobes.
- R5: After reset, the control register holds the RESET_VALUE parameter. The active parent and ratio are taken from that value. With the default parameters this is 0x0100: parent 1 is selected (field at bits 9:8) and the ratio field (bits 3:0) is 0.
- R6: With a select field width of zero, the block has no select field and always divides parent 0.
- R7: A new ratio written while a period is running applies only after the current period ends with its strobe. That period keeps its old length.
- R8: A write that changes the select field value restarts the count. No output strobe appears in the cycle after that write. The first strobe from the new parent comes after a full N strobes of that parent.
- R9: The output strobe is high for one system cycle. It appears in the cycle after the Nth selected parent strobe. Strobes on parents that are not selected have no effect.
- R10: A select value at or above NUM_PARENTS selects no parent, and no output strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 32 | Bits 31:16 are per-bit write enables; bits 15:0 are the data |
| rd_data | output | 32 | Control register read value, upper half zero |
| parent_tick | input | NUM_PARENTS | One enable strobe per parent source |
| out_tick | output | 1 | Divided output strobe |

## Verification
A control write is visible on the read port from the first sampling point after the clock edge that takes it, so read checks follow each write directly.

The output strobe is registered once. It therefore appears in the cycle after the parent strobe that closes a period. The bench drives each parent strobe on a falling edge and follows it with a gap cycle, and it counts output strobes on falling edges. Each ratio case sends a known number of parent strobes and then waits one extra cycle. The accumulated count is then exact, and a strobe seen on two consecutive samples is flagged.

The vector table forces a clean start before every entry by moving the select to an idle index and back. Directed cases then place a ratio write or a select change in the middle of a period.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int CTRL_W  = 16;
    localparam int EN_LSB  = 16;

    typedef enum logic {
        RATIO_LINEAR = 1'b0,
        RATIO_POW2   = 1'b1
    } ratio_mode_e;
endpackage

// File: rtl/ctrl_reg.sv
module ctrl_reg
    import clkdiv_pkg::*;
#(
    parameter logic [CTRL_W-1:0] RESET_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [CTRL_W-1:0] ctrl_now,
    output logic [CTRL_W-1:0] ctrl_next
);
    typedef struct packed {
        logic [CTRL_W-1:0] bits;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic [CTRL_W-1:0] bit_en;

    always_comb begin
        st_d   = st_q;
        bit_en = wr_data[EN_LSB +: CTRL_W];
        if (wr_en) begin
            st_d.bits = (st_q.bits & ~bit_en) | (wr_data[CTRL_W-1:0] & bit_en);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bits <= RESET_VALUE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_now  = st_q.bits;
    assign ctrl_next = st_d.bits;
endmodule

// File: rtl/ratio_decode.sv
module ratio_decode
    import clkdiv_pkg::*;
#(
    parameter int          RATIO_W = 4,
    parameter int          LIM_W   = 4,
    parameter ratio_mode_e MODE    = RATIO_LINEAR
) (
    input  logic [RATIO_W-1:0] field,
    output logic [LIM_W-1:0]   limit
);
    generate
        if (MODE == RATIO_POW2) begin : g_pow2
            always_comb begin
                limit = (LIM_W'(1) << field) - LIM_W'(1);
            end
        end else begin : g_linear
            always_comb begin
                limit = LIM_W'(field);
            end
        end
    endgenerate
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int LIM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic             restart,
    input  logic [LIM_W-1:0] next_limit,
    input  logic [LIM_W-1:0] reset_limit,
    output logic             tick_out
);
    typedef struct packed {
        logic [LIM_W-1:0] cnt;
        logic [LIM_W-1:0] limit;
        logic             pulse;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (restart) begin
            st_d.cnt   = '0;
            st_d.limit = next_limit;
        end else if (tick_in) begin
            if (st_q.cnt == st_q.limit) begin
                st_d.pulse = 1'b1;
                st_d.cnt   = '0;
                st_d.limit = next_limit;
            end else begin
                st_d.cnt = st_q.cnt + LIM_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.limit <= reset_limit;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_out = st_q.pulse;
endmodule

// File: rtl/clksel_divider.sv
module clksel_divider
    import clkdiv_pkg::*;
#(
    parameter int          NUM_PARENTS = 3,
    parameter int          SEL_POS     = 8,
    parameter int          SEL_W       = 2,
    parameter int          RATIO_POS   = 0,
    parameter int          RATIO_W     = 4,
    parameter ratio_mode_e MODE        = RATIO_LINEAR,
    parameter logic [15:0] RESET_VALUE = 16'h0100
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [31:0]            wr_data,
    output logic [31:0]            rd_data,
    input  logic [NUM_PARENTS-1:0] parent_tick,
    output logic                   out_tick
);
    localparam int LIM_W = (MODE == RATIO_POW2) ? (2 ** RATIO_W) : RATIO_W;

    logic [CTRL_W-1:0]  ctrl_now, ctrl_next;
    logic [LIM_W-1:0]   lim_next, lim_reset;
    logic               sel_tick;
    logic               sel_restart;

    ctrl_reg #(.RESET_VALUE(RESET_VALUE)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ctrl_now (ctrl_now),
        .ctrl_next(ctrl_next)
    );

    ratio_decode #(.RATIO_W(RATIO_W), .LIM_W(LIM_W), .MODE(MODE)) u_dec_next (
        .field(ctrl_next[RATIO_POS +: RATIO_W]),
        .limit(lim_next)
    );

    ratio_decode #(.RATIO_W(RATIO_W), .LIM_W(LIM_W), .MODE(MODE)) u_dec_rst (
        .field(RESET_VALUE[RATIO_POS +: RATIO_W]),
        .limit(lim_reset)
    );

    generate
        if (SEL_W == 0) begin : g_nomux
            always_comb begin
                sel_tick    = parent_tick[0];
                sel_restart = 1'b0;
            end
        end else begin : g_mux
            logic [SEL_W-1:0] sel_now, sel_next;
            always_comb begin
                sel_now     = ctrl_now[SEL_POS +: SEL_W];
                sel_next    = ctrl_next[SEL_POS +: SEL_W];
                sel_restart = (sel_now != sel_next);
                sel_tick    = 1'b0;
                for (int i = 0; i < NUM_PARENTS; i++) begin
                    if (32'(sel_now) == i) sel_tick = parent_tick[i];
                end
            end
        end
    endgenerate

    tick_divider #(.LIM_W(LIM_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_in    (sel_tick),
        .restart    (sel_restart),
        .next_limit (lim_next),
        .reset_limit(lim_reset),
        .tick_out   (out_tick)
    );

    assign rd_data = {16'h0000, ctrl_now};
endmodule

// File: rtl/clksel_divider_chk.sv
module clksel_divider_chk #(
    parameter int NUM_PARENTS = 3,
    parameter int SEL_POS     = 8,
    parameter int SEL_W       = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [31:0]            wr_data,
    input logic [31:0]            rd_data,
    input logic [NUM_PARENTS-1:0] parent_tick,
    input logic                   out_tick
);
    p_masked_update_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> rd_data[15:0] ==
            (($past(rd_data[15:0]) & ~$past(wr_data[31:16])) |
             ($past(wr_data[15:0]) & $past(wr_data[31:16]))));

    p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(rd_data));

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:16] == 16'h0000);

    p_strobe_follows_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_tick |-> $past(|parent_tick));

    generate
        if (SEL_W > 0) begin : g_sel
            p_bad_sel_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
                out_tick |-> (32'($past(rd_data[SEL_POS +: SEL_W])) < NUM_PARENTS));

            p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_data[SEL_POS +: SEL_W] != $past(rd_data[SEL_POS +: SEL_W])) |=> !out_tick);
        end
    endgenerate
endmodule

bind clksel_divider clksel_divider_chk #(
    .NUM_PARENTS(NUM_PARENTS),
    .SEL_POS    (SEL_POS),
    .SEL_W      (SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .parent_tick(parent_tick),
    .out_tick   (out_tick)
);

// File: tb/sim_clksel_divider.sv
module sim_clksel_divider;
    import clkdiv_pkg::*;

    localparam int CLK_PERIOD = 10;
    // entry: sel[21:20] ratio[19:16] ticks[15:8] expected[7:0]
    localparam int NVEC = 6;
    localparam logic [21:0] VEC [NVEC] = '{
        {2'd0, 4'd0,  8'd5,  8'd5},
        {2'd0, 4'd3,  8'd12, 8'd3},
        {2'd1, 4'd2,  8'd10, 8'd3},
        {2'd2, 4'd15, 8'd32, 8'd2},
        {2'd1, 4'd1,  8'd7,  8'd3},
        {2'd2, 4'd4,  8'd9,  8'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr0 = 1'b0, wr1 = 1'b0;
    logic [31:0] wd0 = '0, wd1 = '0;
    logic [31:0] rd0, rd1;
    logic [2:0]  pt0 = '0;
    logic [0:0]  pt1 = '0;
    logic        out0, out1;

    int checks = 0, fails = 0;
    int cnt0 = 0, cnt1 = 0, dbl0 = 0;
    logic prev0 = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clksel_divider u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr0), .wr_data(wd0), .rd_data(rd0),
        .parent_tick(pt0), .out_tick(out0)
    );

    clksel_divider #(
        .NUM_PARENTS(1), .SEL_POS(0), .SEL_W(0), .RATIO_POS(4), .RATIO_W(3),
        .MODE(RATIO_POW2), .RESET_VALUE(16'h0000)
    ) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr1), .wr_data(wd1), .rd_data(rd1),
        .parent_tick(pt1), .out_tick(out1)
    );

    always @(negedge clk) begin
        if (out0) cnt0++;
        if (out0 && prev0) dbl0++;
        prev0 = out0;
        if (out1) cnt1++;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic write0(input logic [31:0] d);
        @(negedge clk); wr0 = 1'b1; wd0 = d;
        @(negedge clk); wr0 = 1'b0; wd0 = '0;
    endtask

    task automatic write1(input logic [31:0] d);
        @(negedge clk); wr1 = 1'b1; wd1 = d;
        @(negedge clk); wr1 = 1'b0; wd1 = '0;
    endtask

    // strobe parent sel k times; other parents also toggle in gap cycles
    task automatic tick0(input int sel, input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); pt0 = 3'b111;
            @(negedge clk); pt0 = (sel < 3) ? ~(3'b001 << sel) : 3'b000;
        end
        @(negedge clk); pt0 = '0;
        @(negedge clk);
    endtask

    task automatic tick1(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); pt1 = 1'b1;
            @(negedge clk); pt1 = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic restart0(input int sel, input int ratio);
        write0(32'hFFFF_0300);
        write0({16'hFFFF, 6'd0, 2'(sel), 4'd0, 4'(ratio)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 reset contents and reset parent selection
        check("R5 reset u0", rd0, 32'h0000_0100);
        check("R5 reset u1", rd1, 32'h0000_0000);
        base = cnt0; tick0(1, 3);
        check("R5 reset parent1 ratio0", 32'(cnt0 - base), 32'd3);

        // R3 R9 vector table
        for (int v = 0; v < NVEC; v++) begin
            restart0(int'(VEC[v][21:20]), int'(VEC[v][19:16]));
            base = cnt0;
            tick0(int'(VEC[v][21:20]), int'(VEC[v][15:8]));
            check("R3 R9 linear ratio vector", 32'(cnt0 - base), 32'(VEC[v][7:0]));
        end

        // R1 masked writes, R2 upper half
        write0(32'h000F_FFFF);
        check("R1 ratio-only write", rd0, 32'h0000_020F);
        write0(32'h0000_FFFF);
        check("R1 zero-enable write", rd0, 32'h0000_020F);
        write0(32'h0300_0000);
        check("R1 select-only write", rd0, 32'h0000_000F);
        write0(32'hFFFF_FFFF);
        check("R2 upper bits zero", rd0, 32'h0000_FFFF);

        // R7 ratio change waits for period end
        restart0(0, 3);
        base = cnt0; tick0(0, 2);
        check("R7 mid period", 32'(cnt0 - base), 32'd0);
        write0(32'h000F_0000);
        base = cnt0; tick0(0, 2);
        check("R7 old period completes", 32'(cnt0 - base), 32'd1);
        base = cnt0; tick0(0, 3);
        check("R7 new ratio applied", 32'(cnt0 - base), 32'd3);

        // R8 select change restarts count
        restart0(0, 3);
        base = cnt0; tick0(0, 3);
        check("R8 before switch", 32'(cnt0 - base), 32'd0);
        write0(32'h0300_0100);
        base = cnt0; tick0(1, 3);
        check("R8 restarted count", 32'(cnt0 - base), 32'd0);
        base = cnt0; tick0(1, 1);
        check("R8 full period new parent", 32'(cnt0 - base), 32'd1);

        // R10 out-of-range select
        restart0(3, 0);
        base = cnt0; tick0(3, 5);
        check("R10 no strobe", 32'(cnt0 - base), 32'd0);

        // R9 one-cycle strobe
        check("R9 single-cycle strobe", 32'(dbl0), 32'd0);

        // R4 R6 power-of-two, no select field (ratio bits 6:4)
        base = cnt1; tick1(3);
        check("R4 R6 pow2 n=0", 32'(cnt1 - base), 32'd3);
        write1(32'h0070_0020);
        check("R1 u1 write", rd1, 32'h0000_0020);
        base = cnt1; tick1(1);
        check("R7 u1 old period", 32'(cnt1 - base), 32'd1);
        base = cnt1; tick1(8);
        check("R4 pow2 n=2", 32'(cnt1 - base), 32'd2);
        write1(32'h0070_0030);
        base = cnt1; tick1(4);
        check("R7 u1 period end", 32'(cnt1 - base), 32'd1);
        base = cnt1; tick1(8);
        check("R4 pow2 n=3", 32'(cnt1 - base), 32'd1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule